// File: doc/BRIEF.md
# Depth-Cascaded Dual-Port RAM Stack

This block builds one deep, wide memory out of a grid of small dual-port RAM banks. Each bank is either 256 words of 9 bits or 128 words of 18 bits. A parameter picks the shape, and every bank has its own write clock and read clock. The grid has `NUM_BANKS` rows and `SLICES` columns. The rows extend the depth. The columns extend the word width: each column keeps one fixed slice of the word, and all columns in a row see the same address.

The low address bits go to every bank. The write address bits above the bank's top address bit are decoded into one-hot row write enables, so a write changes only one row. On the read side, every row's output goes into a multiplexer. The multiplexer select is the upper read address. In clocked read mode it passes through a register loaded under the read enable, so the select stays aligned with the bank output registers. In flow-through mode it is taken directly from the port.

The ports are plain enables with no valid/ready handshake. Writes are always accepted. A read result is due at a fixed time: one read clock edge after the request in clocked mode, and in the same cycle in flow-through mode. The consumer therefore never applies back-pressure; it samples at the known time.

Top module: `deep_ram_stack`

## Requirements
- R1: The memory holds NUM_BANKS times the bank depth words. The low bank-address bits of `waddr`/`raddr` select the word within a row, and the remaining upper bits select the row. A word written to any address reads back from that address and no other.
- R2: A write with `wen` high on a `wclk` edge changes only the row chosen by the upper write address bits. Exactly one row write enable is active in that cycle. Words at the same low address in other rows keep their values.
- R3: When `wen` is low, no row write enable is active and no stored word changes, whatever `waddr` and `wdata` carry.
- R4: Clocked mode (`rd_async` = 0): on a `rclk` edge with `ren` high, `rdata` takes the word stored at `raddr` and holds it until the next such edge.
- R5: Clocked mode: the row select is registered under `ren`. A change of `raddr` while `ren` is low does not change `rdata`.
- R6: Flow-through mode (`rd_async` = 1) with `ren` high: `rdata` shows the word at the current `raddr` with no clock edge, and follows `raddr` as it changes.
- R7: Flow-through mode with `ren` low: `rdata` is all zeros.
- R8: Bits [k*BW +: BW] of a word are held by column k, where BW is the bank width (9 or 18). All columns of a row share the address, so the full `SLICES*BW`-bit word reads back intact.
- R9: While `rrst_n` is low, and after it rises until the first read, clocked-mode `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wen | input | 1 | Write enable |
| waddr | input | AW | Write word address (AW = bank address bits + log2 NUM_BANKS) |
| wdata | input | DW | Write word (DW = SLICES * bank width) |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Active-low asynchronous reset of the read registers |
| rd_async | input | 1 | 1 = flow-through read, 0 = clocked read |
| ren | input | 1 | Read enable (clock enable or flow-through enable) |
| raddr | input | AW | Read word address |
| rdata | output | DW | Read word |

## Verification
A write is stored on the `wclk` edge where `wen` is high, so the bench can read it from the following cycle on. A clocked read is due just after the `rclk` edge that sees `ren` high. The bench drives requests on the falling edge and compares `rdata` on the next falling edge, one full edge after the capture. A flow-through read is due within the same cycle, so the bench changes `raddr` and compares after a short settling delay, with no clock edge in between. The hold checks move `raddr` with `ren` low and compare one full cycle later, when a wrong reload would already be visible.

// File: rtl/deep_ram_pkg.sv
package deep_ram_pkg;

  typedef enum logic {
    RD_CLOCKED = 1'b0,
    RD_FLOW    = 1'b1
  } rd_mode_e;

  // bank shape: narrow = 256 x 9, wide = 128 x 18
  function automatic int bank_addr_bits(input bit wide);
    return wide ? 7 : 8;
  endfunction

  function automatic int bank_data_bits(input bit wide);
    return wide ? 18 : 9;
  endfunction

endpackage

// File: rtl/drs_bank.sv
module drs_bank #(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_async,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  import deep_ram_pkg::*;

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rd_q;
  rd_mode_e      mode;

  assign mode = rd_mode_e'(rd_async);

  always_ff @(posedge wclk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rd_q <= '0;
    else if (re)  rd_q <= mem[ra];
  end

  always_comb begin
    if (mode == RD_FLOW) rd = re ? mem[ra] : '0;
    else                 rd = rd_q;
  end

endmodule

// File: rtl/drs_wdec.sv
module drs_wdec #(
  parameter int NB = 4,
  parameter int SW = 2
) (
  input  logic          we,
  input  logic [SW-1:0] hi,
  output logic [NB-1:0] en
);
  for (genvar b = 0; b < NB; b++) begin : g_row
    assign en[b] = we && (hi == SW'(b));
  end
endmodule

// File: rtl/drs_rsel.sv
module drs_rsel #(
  parameter int NB = 4,
  parameter int SW = 2,
  parameter int W  = 18
) (
  input  logic                  rclk,
  input  logic                  rrst_n,
  input  logic                  rd_async,
  input  logic                  re,
  input  logic [SW-1:0]         hi,
  input  logic [NB-1:0][W-1:0]  row_rd,
  output logic [SW-1:0]         sel_q,
  output logic [W-1:0]          rdata
);
  logic [SW-1:0] sel;

  // aligned with the bank output register: loads on the same edge
  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  sel_q <= '0;
    else if (re)  sel_q <= hi;
  end

  assign sel   = rd_async ? hi : sel_q;
  assign rdata = row_rd[sel];
endmodule

// File: rtl/deep_ram_stack.sv
module deep_ram_stack #(
  parameter int NUM_BANKS = 4,
  parameter bit BANK_WIDE = 1'b0,
  parameter int SLICES    = 2,
  localparam int BAW = deep_ram_pkg::bank_addr_bits(BANK_WIDE),
  localparam int BDW = deep_ram_pkg::bank_data_bits(BANK_WIDE),
  localparam int SW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int AW  = BAW + SW,
  localparam int DW  = BDW * SLICES
) (
  input  logic          wclk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_async,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [NUM_BANKS-1:0]         bank_we;
  logic [NUM_BANKS-1:0][DW-1:0] row_rd;
  logic [SW-1:0]                sel_q;

  drs_wdec #(.NB(NUM_BANKS), .SW(SW)) u_wdec (
    .we (wen),
    .hi (waddr[AW-1 -: SW]),
    .en (bank_we)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_row
    for (genvar s = 0; s < SLICES; s++) begin : g_col
      drs_bank #(.AW(BAW), .DW(BDW)) u_bank (
        .wclk     (wclk),
        .we       (bank_we[b]),
        .wa       (waddr[BAW-1:0]),
        .wd       (wdata[s*BDW +: BDW]),
        .rclk     (rclk),
        .rrst_n   (rrst_n),
        .rd_async (rd_async),
        .re       (ren),
        .ra       (raddr[BAW-1:0]),
        .rd       (row_rd[b][s*BDW +: BDW])
      );
    end
  end

  drs_rsel #(.NB(NUM_BANKS), .SW(SW), .W(DW)) u_rsel (
    .rclk     (rclk),
    .rrst_n   (rrst_n),
    .rd_async (rd_async),
    .re       (ren),
    .hi       (raddr[AW-1 -: SW]),
    .row_rd   (row_rd),
    .sel_q    (sel_q),
    .rdata    (rdata)
  );

endmodule

// File: rtl/deep_ram_stack_chk.sv
module deep_ram_stack_chk #(
  parameter int NB = 4,
  parameter int AW = 10,
  parameter int DW = 18,
  parameter int SW = 2
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rrst_n,
  input logic          wen,
  input logic          ren,
  input logic          rd_async,
  input logic [AW-1:0] raddr,
  input logic [DW-1:0] rdata,
  input logic [NB-1:0] bank_we,
  input logic [SW-1:0] sel_q
);
  AST_ONE_ROW_WRITES: assert property (@(posedge wclk) disable iff (!rrst_n)
    wen |-> ($countones(bank_we) == 1)); // R2

  AST_IDLE_NO_WRITE: assert property (@(posedge wclk) disable iff (!rrst_n)
    !wen |-> (bank_we == '0)); // R3

  AST_SEL_LOADS: assert property (@(posedge rclk) disable iff (!rrst_n)
    ren |=> (sel_q == $past(raddr[AW-1 -: SW]))); // R5

  AST_SEL_HOLDS: assert property (@(posedge rclk) disable iff (!rrst_n)
    !ren |=> $stable(sel_q)); // R5

  AST_CLOCKED_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!ren && !rd_async) |=> (rd_async || $stable(rdata))); // R4

  AST_FLOW_IDLE_ZERO: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_async && !ren) |-> (rdata == '0)); // R7
endmodule

bind deep_ram_stack deep_ram_stack_chk #(
  .NB(NUM_BANKS), .AW(AW), .DW(DW), .SW(SW)
) chk_i (
  .wclk     (wclk),
  .rclk     (rclk),
  .rrst_n   (rrst_n),
  .wen      (wen),
  .ren      (ren),
  .rd_async (rd_async),
  .raddr    (raddr),
  .rdata    (rdata),
  .bank_we  (bank_we),
  .sel_q    (sel_q)
);

// File: tb/deep_ram_stack_tb_top.sv
`timescale 1ns/1ps
module deep_ram_stack_tb_top;
  localparam int NB    = 4;
  localparam int BAW   = 8;
  localparam int AW    = 10;
  localparam int DW    = 18;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rrst_n = 1'b0;
  logic wen = 1'b0, ren = 1'b0, rd_async = 1'b0;
  logic [AW-1:0] waddr = '0, raddr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  deep_ram_stack #(.NUM_BANKS(NB), .BANK_WIDE(1'b0), .SLICES(2)) dut_i (
    .wclk(clk), .wen(wen), .waddr(waddr), .wdata(wdata),
    .rclk(clk), .rrst_n(rrst_n), .rd_async(rd_async), .ren(ren),
    .raddr(raddr), .rdata(rdata)
  );

  // distinct per address: upper 10 bits are a bijection of the address
  function automatic logic [DW-1:0] pat(input int a, input int seed);
    logic [AW-1:0] av = AW'(a);
    return {av ^ AW'(seed), av[7:0] ^ 8'(seed >> 2)};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wen = 1'b1; waddr = AW'(a); wdata = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd_clk(input int a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    rd_async = 1'b0; ren = 1'b1; raddr = AW'(a);
    @(negedge clk);
    ren = 1'b0;
    check(req, rdata, exp);
  endtask

  task automatic rd_flow(input int a, input logic [DW-1:0] exp, input string req);
    rd_async = 1'b1; ren = 1'b1; raddr = AW'(a);
    #0.5;
    check(req, rdata, exp);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    int a0;
    repeat (3) @(negedge clk);
    check("R9 reset", rdata, '0);
    rrst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", rdata, '0);

    // R1 R2 R8: fill every address in every row, full word width
    for (int a = 0; a < WORDS; a++) begin
      @(negedge clk);
      wen = 1'b1; waddr = AW'(a); wdata = pat(a, 'h2A5);
    end
    @(negedge clk);
    wen = 1'b0;

    // R1 R4 R8: clocked readback of all words
    for (int a = 0; a < WORDS; a++) rd_clk(a, pat(a, 'h2A5), "R1 R4 R8 clocked");

    // R5: raddr moves to another row with ren low, rdata must hold
    rd_clk(17, pat(17, 'h2A5), "R4 load");
    @(negedge clk);
    raddr = AW'(3 * 256 + 40);
    @(negedge clk);
    @(negedge clk);
    check("R5 hold on raddr change", rdata, pat(17, 'h2A5));

    // R3: write attempts with wen low leave the word unchanged
    @(negedge clk);
    wen = 1'b0; waddr = AW'(300); wdata = ~pat(300, 'h2A5);
    repeat (3) @(negedge clk);
    rd_clk(300, pat(300, 'h2A5), "R3 no write with wen low");

    // R2: one write in row 1 leaves the same low address in other rows
    a0 = 77;
    wr(256 + a0, 18'h15A5A);
    for (int b = 0; b < NB; b++) begin
      if (b == 1) rd_clk(b * 256 + a0, 18'h15A5A, "R2 target row written");
      else        rd_clk(b * 256 + a0, pat(b * 256 + a0, 'h2A5), "R2 other row kept");
    end
    wr(256 + a0, pat(256 + a0, 'h2A5));

    // R6 R8: flow-through readback, no clock edge between change and sample
    for (int a = 0; a < WORDS; a++) begin
      @(negedge clk);
      rd_flow(a, pat(a, 'h2A5), "R6 R8 flow");
    end

    // R6: follows raddr twice within one low phase
    @(negedge clk);
    rd_flow(5, pat(5, 'h2A5), "R6 follow first");
    rd_flow(2 * 256 + 5, pat(2 * 256 + 5, 'h2A5), "R6 follow second");

    // R7: flow-through with ren low reads zero
    ren = 1'b0;
    #0.5;
    check("R7 flow idle zero", rdata, '0);

    // R1: second pattern overwrites every word, then clocked readback
    for (int a = 0; a < WORDS; a++) begin
      @(negedge clk);
      rd_async = 1'b0; wen = 1'b1; waddr = AW'(a); wdata = pat(a, 'h0F3);
    end
    @(negedge clk);
    wen = 1'b0;
    for (int a = 0; a < WORDS; a++) rd_clk(a, pat(a, 'h0F3), "R1 second pattern");

    done = 1'b1;
    finish_run();
  end
endmodule